// File: doc/BRIEF.md
# Frame-Preemption Control and Status Registers

This block holds the software-visible registers for a MAC's frame-preemption function on a simple 32-bit register bus. Software uses it to turn preemption on and to ask a transmitter to send a Verify or a Response mPacket. Each request leaves the block as a one-cycle pulse. The transmitter and receiver report handshake progress on four single-cycle event inputs. The block latches those events into sticky flags, and any read of the control word clears them.

A second word carries the mask of transmit queues that may be preempted and the additional fragment size. A third word holds an interrupt enable. The interrupt output is raised while any event flag is pending and that enable is set. A control-word read side effect lets software discard events that arrived while the interrupt was masked. A write of command bits leaves pending flags untouched.

The bus is a single-cycle strobe (`csr_en`, with `csr_we` selecting write). Read data is registered and appears in the cycle after the read strobe. Outside a read cycle the read data returns zero.

Top module: `fpe_csr`

## Requirements
- R1: After reset every output is zero, and all three registers (byte offsets 0x0 control, 0x4 queue, 0x8 interrupt enable) read back as zero.
- R2: A write to offset 0x0 loads bit 0 into the preemption enable. The enable drives `pmp_enable` from the next cycle and reads back at bit 0.
- R3: A write to offset 0x0 with bit 1 set gives exactly one cycle of `tx_verify_req` in the cycle after the write. Bit 1 always reads back as 0.
- R4: A write to offset 0x0 with bit 2 set gives exactly one cycle of `tx_resp_req` in the cycle after the write. Bit 2 always reads back as 0.
- R5: Event inputs set sticky flags in the control word at these positions: received Verify at bit 16, received Response at bit 17, transmitted Verify at bit 18, transmitted Response at bit 19. Flags accumulate until read.
- R6: A read of offset 0x0 returns the flags as they stood before the read. It clears all four flags in the same cycle.
- R7: An event arriving in the same cycle as a control-word read is not returned by that read. It remains set afterwards.
- R8: Writes to any register leave the event flags unchanged.
- R9: Offset 0x4 holds the preemptible-queue mask in bits 15:8 and the additional fragment size in bits 1:0. Both drive outputs and read back. Other bits read as zero.
- R10: Offset 0x8 bit 0 is the interrupt enable. `irq` is high when that enable is set and any flag is pending. A control-word read while the interrupt is masked discards pending events, so enabling afterwards raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Bus access strobe, one cycle per access |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | ADDR_W | Byte address of the register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data, valid the cycle after a read |
| evt_rx_verify | input | 1 | Pulse: Verify mPacket received |
| evt_rx_resp | input | 1 | Pulse: Response mPacket received |
| evt_tx_verify | input | 1 | Pulse: Verify mPacket transmitted |
| evt_tx_resp | input | 1 | Pulse: Response mPacket transmitted |
| pmp_enable | output | 1 | Preemption enable to the MAC |
| tx_verify_req | output | 1 | One-cycle request to send a Verify mPacket |
| tx_resp_req | output | 1 | One-cycle request to send a Response mPacket |
| preempt_qmask | output | QUEUES | Preemptible transmit-queue mask |
| frag_extra | output | FRAG_W | Additional fragment size |
| irq | output | 1 | Preemption event interrupt |

## Verification
Each event input is fired alone and then in combination. This shows that every flag lands on its own bit and that flags accumulate. Reads are placed with no event, with an event in the same cycle, and right after a command write. These three cases separate plain clear-on-read from a read that loses a simultaneous event and from a write that corrupts status. Command writes use the enable, the Verify and the Response bits separately and together, which exposes crossed or sticky request pulses. The interrupt is tried unmasked, masked, and masked followed by a clearing read then enabling, which tells gating apart from discard.

// File: rtl/fpe_csr.sv
module fpe_csr #(
  parameter int ADDR_W = 4,
  parameter int QUEUES = 8,
  parameter int FRAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              evt_rx_verify,
  input  logic              evt_rx_resp,
  input  logic              evt_tx_verify,
  input  logic              evt_tx_resp,
  output logic              pmp_enable,
  output logic              tx_verify_req,
  output logic              tx_resp_req,
  output logic [QUEUES-1:0] preempt_qmask,
  output logic [FRAG_W-1:0] frag_extra,
  output logic              irq
);
  localparam int FLAG_LSB = 16;
  localparam int QMASK_LSB = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_QUEUE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_IRQEN = ADDR_W'(8);

  logic [3:0]  flags;
  logic [3:0]  evt;
  logic        irq_en;
  logic [31:0] rd_mux;
  logic        unused_wdata;

  wire wr = csr_en & csr_we;
  wire rd = csr_en & ~csr_we;
  wire hit_ctrl = (csr_addr == OFS_CTRL);
  wire hit_queue = (csr_addr == OFS_QUEUE);
  wire hit_irqen = (csr_addr == OFS_IRQEN);

  assign evt = {evt_tx_resp, evt_tx_verify, evt_rx_resp, evt_rx_verify};
  assign irq = irq_en & (|flags);
  assign unused_wdata = ^csr_wdata;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[0] = pmp_enable;
      rd_mux[FLAG_LSB +: 4] = flags;
    end else if (hit_queue) begin
      rd_mux[QMASK_LSB +: QUEUES] = preempt_qmask;
      rd_mux[FRAG_W-1:0] = frag_extra;
    end else if (hit_irqen) begin
      rd_mux[0] = irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags         <= '0;
      irq_en        <= 1'b0;
      pmp_enable    <= 1'b0;
      tx_verify_req <= 1'b0;
      tx_resp_req   <= 1'b0;
      preempt_qmask <= '0;
      frag_extra    <= '0;
      csr_rdata     <= '0;
    end else begin
      tx_verify_req <= wr & hit_ctrl & csr_wdata[1];
      tx_resp_req   <= wr & hit_ctrl & csr_wdata[2];
      if (wr && hit_ctrl) pmp_enable <= csr_wdata[0];
      if (wr && hit_queue) begin
        preempt_qmask <= csr_wdata[QMASK_LSB +: QUEUES];
        frag_extra    <= csr_wdata[FRAG_W-1:0];
      end
      if (wr && hit_irqen) irq_en <= csr_wdata[0];
      flags     <= (rd && hit_ctrl) ? evt : (flags | evt);
      csr_rdata <= rd ? rd_mux : '0;
    end
  end
endmodule

module fpe_csr_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_en,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [31:0]       csr_wdata,
  input logic [3:0]        evt,
  input logic              irq_en,
  input logic              pmp_enable,
  input logic              tx_verify_req,
  input logic              tx_resp_req,
  input logic              irq
);
  wire ctrl_wr = csr_en & csr_we & (csr_addr == ADDR_W'(0));
  wire ctrl_rd = csr_en & ~csr_we & (csr_addr == ADDR_W'(0));

  AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (pmp_enable == $past(csr_wdata[0]))); // R2
  AST_VERIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (tx_verify_req == $past(csr_wdata[1]))); // R3
  AST_VERIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> !tx_verify_req); // R3
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (tx_resp_req == $past(csr_wdata[2]))); // R4
  AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> !tx_resp_req); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && evt == 4'b0) |=> !irq); // R6
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (|evt) && !(csr_en && csr_we)) |=> irq); // R7
  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ctrl_wr) |=> irq); // R8
endmodule

bind fpe_csr fpe_csr_chk #(.ADDR_W(ADDR_W)) u_fpe_csr_chk (
  .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .evt(evt), .irq_en(irq_en),
  .pmp_enable(pmp_enable), .tx_verify_req(tx_verify_req),
  .tx_resp_req(tx_resp_req), .irq(irq)
);

// File: tb/test_fpe_csr.sv
module test_fpe_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_en = 1'b0, csr_we = 1'b0;
  logic [3:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [3:0] ev = '0;
  logic pmp_enable, tx_verify_req, tx_resp_req, irq;
  logic [7:0] preempt_qmask;
  logic [1:0] frag_extra;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpe_csr i_fpe_csr (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .evt_rx_verify(ev[0]), .evt_rx_resp(ev[1]), .evt_tx_verify(ev[2]),
    .evt_tx_resp(ev[3]), .pmp_enable(pmp_enable),
    .tx_verify_req(tx_verify_req), .tx_resp_req(tx_resp_req),
    .preempt_qmask(preempt_qmask), .frag_extra(frag_extra), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= csr_en & ~csr_we;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, csr_rdata, e);
    end
  end

  task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag,
                          logic [3:0] evs = 4'b0);
    @(negedge clk);
    csr_en = 1; csr_we = 0; csr_addr = a; ev = evs;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    csr_en = 0; ev = 4'b0;
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 0; csr_we = 0; csr_wdata = 0;
  endtask

  task automatic fire(logic [3:0] evs);
    @(negedge clk);
    ev = evs;
    @(negedge clk);
    ev = 4'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs", {26'b0, pmp_enable, tx_verify_req, tx_resp_req, irq, frag_extra}, 0);
    check("R1 qmask", {24'b0, preempt_qmask}, 0);
    bus_read(4'h0, 0, "R1 ctrl");
    bus_read(4'h4, 0, "R1 queue");
    bus_read(4'h8, 0, "R1 irqen");

    // enable and send pulses
    bus_write(4'h0, 32'h1);
    check("R2 enable out", {31'b0, pmp_enable}, 1);
    check("R3 no verify", {31'b0, tx_verify_req}, 0);
    bus_read(4'h0, 32'h1, "R2 readback");
    bus_write(4'h0, 32'h3);
    check("R3 verify pulse", {30'b0, tx_verify_req, tx_resp_req}, 32'h2);
    @(negedge clk);
    check("R3 verify one cycle", {31'b0, tx_verify_req}, 0);
    bus_read(4'h0, 32'h1, "R3 bit1 reads 0");
    bus_write(4'h0, 32'h5);
    check("R4 resp pulse", {30'b0, tx_verify_req, tx_resp_req}, 32'h1);
    @(negedge clk);
    check("R4 resp one cycle", {31'b0, tx_resp_req}, 0);
    bus_write(4'h0, 32'h6);
    check("R4 both pulses", {30'b0, tx_verify_req, tx_resp_req}, 32'h3);
    check("R2 enable cleared", {31'b0, pmp_enable}, 0);
    bus_read(4'h0, 32'h0, "R4 bit2 reads 0");

    // event flags
    for (int i = 0; i < 4; i++) begin
      fire(4'b1 << i);
      bus_read(4'h0, 32'h1 << (16 + i), "R5 single flag");
    end
    fire(4'b0001);
    fire(4'b1000);
    bus_read(4'h0, 32'h0009_0000, "R5 accumulate");
    bus_read(4'h0, 32'h0, "R6 cleared after read");

    // simultaneous event and read
    fire(4'b0010);
    bus_read(4'h0, 32'h0002_0000, "R7 old flags returned", 4'b0100);
    bus_read(4'h0, 32'h0004_0000, "R7 new event kept");

    // writes keep status
    fire(4'b0101);
    bus_write(4'h0, 32'h7);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'h0);
    bus_read(4'h0, 32'h0005_0001, "R8 flags after writes");

    // queue register
    bus_read(4'h4, 32'h0000_FF03, "R9 queue all ones");
    check("R9 outputs", {22'b0, preempt_qmask, frag_extra}, {22'b0, 8'hFF, 2'h3});
    bus_write(4'h4, 32'h0000_A502);
    bus_read(4'h4, 32'h0000_A502, "R9 queue pattern");
    check("R9 outputs pattern", {22'b0, preempt_qmask, frag_extra}, {22'b0, 8'hA5, 2'h2});
    bus_read(4'h0, 32'h0000_0001, "R9 queue write leaves ctrl");

    // interrupt
    bus_write(4'h8, 32'h1);
    bus_read(4'h8, 32'h1, "R10 irqen readback");
    check("R10 irq idle", {31'b0, irq}, 0);
    fire(4'b0100);
    check("R10 irq raised", {31'b0, irq}, 1);
    bus_read(4'h0, 32'h0004_0001, "R10 read flags");
    check("R10 irq cleared by read", {31'b0, irq}, 0);
    bus_write(4'h8, 32'h0);
    fire(4'b1000);
    check("R10 irq masked", {31'b0, irq}, 0);
    bus_read(4'h0, 32'h0008_0001, "R10 masked read");
    bus_write(4'h8, 32'h1);
    check("R10 no irq after discard", {31'b0, irq}, 0);

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule